// File: doc/BRIEF.md
# Two-Requester Shared Memory Bus Arbiter

This block lets two serial memory controllers take turns on one external memory bus. Each controller raises its request line when it wants the bus and keeps it high for as long as it needs the bus. The arbiter grants the bus to one controller at a time by raising that controller's acknowledge line. Before any new grant it inserts a programmable idle gap, so the bus settles between one owner and the next.

A one-bit owner index and a bus-valid flag drive the downstream data-path multiplexer, which switches the data lines, data strobe and clock pair. The arbiter itself passes the owning controller's chip-select lines to the port. When the multiplex enable is low, the block does no arbitration: every acknowledge simply follows its own request. The limits on how long a controller keeps the bus live inside the controllers, not here.

The block has no streaming data interface. All pins are plain level-sensitive control signals, sampled on the rising clock edge. Requests carry no back-pressure beyond the acknowledge itself.

Top module: `bus_share_arbiter`

## Requirements
- R1: While mux_en is 0, each ack bit equals its own req bit in the same cycle, bus_valid is 0 and port_cs_n is all ones.
- R2: During reset, both ack bits are 0, bus_valid is 0 and port_cs_n is all ones.
- R3: With the arbiter idle and mux_en at 1, a request first sampled at clock edge P raises the chosen ack right after edge P+G+1, where G is gap_cycles (0 to 255); it never rises earlier.
- R4: When the owner's req is sampled low at edge E, its ack is low right after edge E.
- R5: After reset, if requester 0 and requester 1 ask at the same time, requester 0 gets the first grant.
- R6: If the other requester is asking when the owner releases at edge E, it gets ack right after edge E+G+1. Whenever both are asking at the grant decision, the requester that did not own the bus last wins.
- R7: The owner's ack stays high for as long as its req stays high, even if the other requester is asking.
- R8: While mux_en is 1, at most one ack bit is high.
- R9: While mux_en is 1, bus_valid is high exactly when an ack is high, and owner_idx then gives the index of that ack (0 or 1).
- R10: While bus_valid is high, port_cs_n equals the owner's chip-select input (cs0_n for owner 0, cs1_n for owner 1). Otherwise it is all ones.
- R11: If the owner releases while nobody else is asking, the arbiter goes idle. A later request from either side again waits the full G+1 cycles from when it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mux_en | input | 1 | 1 enables arbitration; 0 makes each ack follow its req |
| gap_cycles | input | GAP_W (8) | Switch gap minus one, in clock cycles |
| req | input | 2 | Bus request, bit i from requester i |
| ack | output | 2 | Bus grant, bit i to requester i |
| cs0_n | input | CS_W (2) | Chip selects of requester 0, active low |
| cs1_n | input | CS_W (2) | Chip selects of requester 1, active low |
| port_cs_n | output | CS_W (2) | Chip selects driven to the shared port, active low |
| owner_idx | output | 1 | Index of the current owner, meaningful while bus_valid is 1 |
| bus_valid | output | 1 | A requester currently owns the bus |

## Verification
A wrong state register or a counter that is off by one shows up as an ack edge in the wrong cycle. The bench therefore records the exact cycle in which every grant is expected, and flags any rise that is one cycle early or late. A bad round-robin memory shows up at the next contested handover as an ack to the wrong requester. A broken hold or release path shows up within one cycle as an ack that drops while its req is still high, or that stays high after its req has fallen. Chip-select routing faults show up on port_cs_n as soon as the owner changes, or whenever the bus goes idle.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam int unsigned NREQ = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/bsa_gap_timer.sv
module bsa_gap_timer #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q;

  // Loaded on the edge that opens a gap; counts down while the gap runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bsa_rr_pick.sv
module bsa_rr_pick (
  input  logic [1:0] req,
  input  logic       last_owner,
  output logic       pick,
  output logic       any
);
  // When both are asking, the one that did not own the bus last goes first.
  always_comb begin
    any = |req;
    if (req == 2'b11) begin
      pick = ~last_owner;
    end else if (req[0]) begin
      pick = 1'b0;
    end else begin
      pick = 1'b1;
    end
  end
endmodule

// File: rtl/bsa_handover_fsm.sv
module bsa_handover_fsm
  import bsa_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NREQ-1:0] req,
  input  logic            expired,
  input  logic            pick,
  input  logic            any,
  output logic            load,
  output logic            run,
  output logic [NREQ-1:0] ack_q,
  output logic            owner_q,
  output logic            own_q
);
  arb_state_t state_q;

  // The reset value of owner_q makes requester 0 the first winner of a tie.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= '0;
      owner_q <= 1'b1;
    end else if (!en) begin
      state_q <= ST_IDLE;
      ack_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (|req) state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (expired) begin
            if (any) begin
              state_q    <= ST_OWN;
              owner_q    <= pick;
              ack_q      <= '0;
              ack_q[pick] <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_OWN: begin
          if (!req[owner_q]) begin
            ack_q   <= '0;
            state_q <= req[~owner_q] ? ST_GAP : ST_IDLE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          ack_q   <= '0;
        end
      endcase
    end
  end

  // A gap starts on a request from idle, or on a release with the other side waiting.
  always_comb begin
    load = en && (((state_q == ST_IDLE) && (|req)) ||
                  ((state_q == ST_OWN) && !req[owner_q] && req[~owner_q]));
    run   = (state_q == ST_GAP);
    own_q = (state_q == ST_OWN);
  end
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
  import bsa_pkg::*;
#(
  parameter int unsigned GAP_W = 8,
  parameter int unsigned CS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mux_en,
  input  logic [GAP_W-1:0] gap_cycles,
  input  logic [1:0]       req,
  output logic [1:0]       ack,
  input  logic [CS_W-1:0]  cs0_n,
  input  logic [CS_W-1:0]  cs1_n,
  output logic [CS_W-1:0]  port_cs_n,
  output logic             owner_idx,
  output logic             bus_valid
);
  logic            tmr_load;
  logic            tmr_run;
  logic            tmr_expired;
  logic            rr_pick;
  logic            rr_any;
  logic [NREQ-1:0] ack_q;
  logic            owner_q;
  logic            own_q;

  bsa_gap_timer #(.GAP_W(GAP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (gap_cycles),
    .run      (tmr_run),
    .expired  (tmr_expired)
  );

  bsa_rr_pick u_pick (
    .req        (req),
    .last_owner (owner_q),
    .pick       (rr_pick),
    .any        (rr_any)
  );

  bsa_handover_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mux_en),
    .req     (req),
    .expired (tmr_expired),
    .pick    (rr_pick),
    .any     (rr_any),
    .load    (tmr_load),
    .run     (tmr_run),
    .ack_q   (ack_q),
    .owner_q (owner_q),
    .own_q   (own_q)
  );

  // With arbitration off, each acknowledge follows its request.
  for (genvar g = 0; g < NREQ; g++) begin : g_ack
    assign ack[g] = mux_en ? ack_q[g] : req[g];
  end

  assign bus_valid = mux_en && own_q;
  assign owner_idx = owner_q;
  assign port_cs_n = !bus_valid ? {CS_W{1'b1}} : (owner_q ? cs1_n : cs0_n);
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int unsigned GAP_W = 8,
  parameter int unsigned CS_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mux_en,
  input logic [GAP_W-1:0] gap_cycles,
  input logic [1:0]       req,
  input logic [1:0]       ack,
  input logic [CS_W-1:0]  port_cs_n,
  input logic             owner_idx,
  input logic             bus_valid
);
  // Counts sampled cycles with arbitration on and no acknowledge high.
  logic [GAP_W:0] low_run;
  logic [GAP_W:0] min_low;

  assign min_low = {1'b0, gap_cycles} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (mux_en && (ack == 2'b00)) begin
      if (low_run != '1) low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
    end
  end

  assert_one_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mux_en |-> $onehot0(ack));

  assert_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mux_en |-> (bus_valid == (ack != 2'b00)));

  assert_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ack[owner_idx]);

  assert_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (port_cs_n == {CS_W{1'b1}}));

  for (genvar i = 0; i < 2; i++) begin : g_per_req
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_en && ack[i] && req[i]) |=> (ack[i] || !mux_en));

    assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_en && ack[i] && !req[i]) |=> (!ack[i] || !mux_en));

    assert_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_en && $rose(ack[i])) |-> (low_run >= min_low));
  end
endmodule

bind bus_share_arbiter bsa_checker #(.GAP_W(GAP_W), .CS_W(CS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mux_en     (mux_en),
  .gap_cycles (gap_cycles),
  .req        (req),
  .ack        (ack),
  .port_cs_n  (port_cs_n),
  .owner_idx  (owner_idx),
  .bus_valid  (bus_valid)
);

// File: tb/bus_share_arbiter_test.sv
`timescale 1ns/1ps
module bus_share_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mux_en;
  logic [7:0] gap_cycles;
  logic [1:0] req;
  logic [1:0] ack;
  logic [1:0] cs0_n;
  logic [1:0] cs1_n;
  logic [1:0] port_cs_n;
  logic       owner_idx;
  logic       bus_valid;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  // Scoreboard: expected grants (requester, cycle, requirement tag).
  int    exp_idx[$];
  int    exp_cyc[$];
  string exp_tag[$];
  logic [1:0] prev_ack = 2'b00;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_share_arbiter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mux_en     (mux_en),
    .gap_cycles (gap_cycles),
    .req        (req),
    .ack        (ack),
    .cs0_n      (cs0_n),
    .cs1_n      (cs1_n),
    .port_cs_n  (port_cs_n),
    .owner_idx  (owner_idx),
    .bus_valid  (bus_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // A request or release is driven at this negedge; the grant is due G+2 cycles on.
  task automatic push(input int idx, input int gap, input string tag);
    exp_idx.push_back(idx);
    exp_cyc.push_back(cyc + gap + 2);
    exp_tag.push_back(tag);
  endtask

  task automatic wait_q();
    while (exp_idx.size() != 0) @(negedge clk);
  endtask

  // Monitor: every ack rising edge while arbitration is on must match the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && mux_en) begin
      for (int i = 0; i < 2; i++) begin
        if (ack[i] && !prev_ack[i]) begin
          if (exp_idx.size() == 0) begin
            chk(1'b0, "R3 unexpected grant", i, -1);
          end else begin
            int    ei;
            int    ec;
            string et;
            ei = exp_idx.pop_front();
            ec = exp_cyc.pop_front();
            et = exp_tag.pop_front();
            chk(ei == i, {et, " grant index"}, i, ei);
            chk(ec == cyc, {et, " grant cycle"}, cyc, ec);
          end
        end
      end
    end
    prev_ack = ack;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mux_en = 1'b0; gap_cycles = 8'd3; req = 2'b00;
    cs0_n = 2'b11; cs1_n = 2'b11;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(ack == 2'b00, "R2 ack", ack, 0);
    chk(bus_valid == 1'b0, "R2 bus_valid", bus_valid, 0);
    chk(port_cs_n == 2'b11, "R2 port_cs_n", port_cs_n, 3);
    rst_n = 1'b1;

    // R1 bypass with arbitration off
    @(negedge clk); req = 2'b10; cs1_n = 2'b01; #1;
    chk(ack == 2'b10, "R1 ack follows req", ack, 2);
    chk(bus_valid == 1'b0, "R1 bus_valid", bus_valid, 0);
    chk(port_cs_n == 2'b11, "R1 port_cs_n", port_cs_n, 3);
    @(negedge clk); req = 2'b01; #1;
    chk(ack == 2'b01, "R1 ack follows req", ack, 1);
    @(negedge clk); req = 2'b00; cs1_n = 2'b11;

    // R5 tie after reset: requester 0 first
    @(negedge clk); mux_en = 1'b1;
    @(negedge clk); req = 2'b11; push(0, 3, "R5");
    wait_q();
    // R7 hold while the other asks
    repeat (8) @(negedge clk);
    chk(ack == 2'b01, "R7 owner keeps ack", ack, 1);
    chk(bus_valid && owner_idx == 1'b0, "R9 owner index 0", owner_idx, 0);
    cs0_n = 2'b10; cs1_n = 2'b01; #1;
    chk(port_cs_n == 2'b10, "R10 cs of owner 0", port_cs_n, 2);

    // R4 release, R6 handover to waiting requester
    @(negedge clk); req[0] = 1'b0; push(1, 3, "R6");
    @(negedge clk);
    chk(ack == 2'b00, "R4 ack drops after release", ack, 0);
    wait_q();
    chk(port_cs_n == 2'b01, "R10 cs of owner 1", port_cs_n, 1);
    chk(owner_idx == 1'b1 && bus_valid, "R9 owner index 1", owner_idx, 1);

    // R6 round robin back to requester 0
    @(negedge clk); req[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk(ack == 2'b10, "R7 owner 1 keeps ack", ack, 2);
    @(negedge clk); req[1] = 1'b0; push(0, 3, "R6");
    wait_q();

    // R6 releasing owner re-asks during the gap: the other side wins
    @(negedge clk); req[1] = 1'b1;
    @(negedge clk); req[0] = 1'b0; push(1, 3, "R6");
    @(negedge clk); req[0] = 1'b1;
    wait_q();
    chk(ack == 2'b10, "R6 contested grant to 1", ack, 2);
    @(negedge clk); req[1] = 1'b0; push(0, 3, "R6");
    wait_q();

    // R11 idle after release with nothing pending, then full gap again
    @(negedge clk); req[0] = 1'b0;
    repeat (20) @(negedge clk);
    chk(bus_valid == 1'b0, "R11 idle bus_valid", bus_valid, 0);
    chk(ack == 2'b00, "R11 idle ack", ack, 0);
    chk(port_cs_n == 2'b11, "R10 idle port_cs_n", port_cs_n, 3);
    @(negedge clk); req[1] = 1'b1; push(1, 3, "R11");
    wait_q();
    @(negedge clk); req[1] = 1'b0;

    // R3 boundary gaps 0 and 255
    repeat (4) @(negedge clk); gap_cycles = 8'd0;
    @(negedge clk); req[0] = 1'b1; push(0, 0, "R3");
    wait_q();
    @(negedge clk); req[0] = 1'b0;
    repeat (4) @(negedge clk); gap_cycles = 8'd255;
    @(negedge clk); req[1] = 1'b1; push(1, 255, "R3");
    wait_q();
    @(negedge clk); req[1] = 1'b0;

    // R2 reset while owned
    repeat (4) @(negedge clk); gap_cycles = 8'd2;
    @(negedge clk); req = 2'b01; push(0, 2, "R3");
    wait_q();
    @(negedge clk); rst_n = 1'b0; #1;
    chk(ack == 2'b00, "R2 ack in reset", ack, 0);
    chk(bus_valid == 1'b0, "R2 bus_valid in reset", bus_valid, 0);
    @(negedge clk); req = 2'b00; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(exp_idx.size() == 0, "R3 scoreboard drained", exp_idx.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule